// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block follows a chain of transfer descriptors in memory for a single DMA channel. A descriptor has a two-word header and then a body whose length depends on its form. The first header word points to the next descriptor. The second header word holds this descriptor's element count, plus the type, address-valid flags and notification request for the *next* descriptor. The attributes of the head descriptor come from the channel control word. The walker reads every word through a word-read port and allows only one request in flight at a time. It loads the source address, destination address, frame count and element count into a parameter set. It then starts the transfer engine with a start/done handshake.

Software writes a control word and a head pointer, optionally pulses the chain-setup strobe, and then pulses start. The control word selects three things: linked-list operation, fast mode (the head descriptor is loaded before the first transfer) and the head descriptor's attributes. A pointer with bit 0 set makes the walker stop after the current descriptor and raise the paused flag. Software clears the flag and pulses start again to continue. A completed-descriptor counter reports progress.

Top module: `ll_desc_walker`

## Requirements
- R1: Control word fields: bit 0 is the head destination-valid flag, bit 2 is the head source-valid flag, bits 5:4 are the head type (1, 2 or 3), bit 7 is the paused flag, bit 8 enables linked-list walking and bit 10 enables fast mode.
- R2: Reset and the chain-setup strobe (honoured only while idle or done) clear the completed counter and load the frame count with 0xFFFF and the element count with 0xFFFFFF. The strobe leaves the addresses unchanged. After reset the paused flag is 0.
- R3: Header word 0 is the next pointer. In header word 1, bits 23:0 are this descriptor's element count, and for the next descriptor bit 24 is source-valid, bit 26 is destination-valid, bit 28 is notify-on-completion and bits 30:29 are the type.
- R4: Descriptor lengths in words, including the header: type 1 is 12. Type 2 is 8 when both valid flags are set and 7 otherwise. Type 3 is 4 when both flags are set and 3 otherwise.
- R5: Body layout. The long forms hold source, then destination, then (type 1 and the long type 2 form only) a word whose bits 15:0 are the frame count. The short forms hold one address, then (type 2 only) the frame word. A short-form address goes to the side whose flag is set. An address whose valid flag is clear is not loaded.
- R6: Reads go to consecutive word addresses starting at the pointer with bits 1:0 cleared. A new request is only issued after the previous response has returned.
- R7: In fast mode the head descriptor is fetched before the first transfer. Otherwise one transfer runs first with the parameters already held, and only then is the head fetched.
- R8: When a descriptor completes and its next pointer has bit 0 set, the walker sets control bit 7 and issues no further read. Start is ignored while bit 7 is set. After bit 7 is cleared, start fetches from the pointer with bits 1:0 cleared.
- R9: A next pointer of 0xFFFFFFFC, or a next type of 0, ends the chain after the current transfer without a read. The walker then reports finished.
- R10: The 16-bit completed counter increases by one for each descriptor-loaded transfer. A transfer that uses the preloaded parameters does not count.
- R11: When a descriptor marked for notification finishes its transfer, blk_end pulses for one cycle.
- R12: xfer_start is a one-cycle pulse, and the parameter outputs hold steady until xfer_done returns.
- R13: With linked-list walking disabled, start runs one transfer with the held parameters and then finishes without reading memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word value |
| ptr_we | input | 1 | Head pointer write strobe |
| ptr_wdata | input | 32 | Head pointer value |
| chain_init | input | 1 | Chain setup strobe |
| start | input | 1 | Start or resume strobe |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 32 | Word read byte address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |
| xfer_start | output | 1 | Transfer engine start pulse |
| xfer_done | input | 1 | Transfer engine completion |
| p_src | output | 32 | Source address parameter |
| p_dst | output | 32 | Destination address parameter |
| p_frames | output | 16 | Frame count parameter |
| p_elems | output | 24 | Element count parameter |
| blk_end | output | 1 | Notification pulse |
| done_cnt | output | 16 | Completed descriptor count |
| paused | output | 1 | Paused flag (control bit 7) |
| ctl_word | output | 16 | Current control word |
| finished | output | 1 | Chain has ended |

## Verification
Several rules are checked by assertions on every cycle. The read port never has two requests outstanding and always uses aligned addresses. The start pulse lasts one cycle. The parameters stay frozen and no read is issued while the engine is busy. No read is issued while paused. The counter only steps by one or clears. The notification pulse only follows a completion. Other behaviours depend on memory contents and the order of events, so only the bench scenarios can show them. These are the decoding of each descriptor form, the steering of a short-form address, fast versus normal ordering (seen through the number of reads before each transfer), pausing and resuming, and ending on either the end pointer or a zero type.

// File: rtl/llw_pkg.sv
package llw_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int CTL_W  = 16;
    localparam int CNT_W  = 16;
    localparam int FRM_W  = 16;
    localparam int ELM_W  = 24;
    localparam int LEN_W  = 4;

    // control word bit positions
    localparam int CB_DSTV  = 0;
    localparam int CB_SRCV  = 2;
    localparam int CB_TLO   = 4;
    localparam int CB_PAUSE = 7;
    localparam int CB_LL    = 8;
    localparam int CB_FAST  = 10;

    // second header word bit positions
    localparam int HB_SRCV = 24;
    localparam int HB_DSTV = 26;
    localparam int HB_BLK  = 28;
    localparam int HB_TLO  = 29;

    localparam logic [ADDR_W-1:0] END_PTR = 32'hFFFF_FFFC;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_BODY, S_EXEC, S_LINK, S_PAUSE, S_DONE
    } walk_state_e;

    typedef struct packed {
        logic [1:0] kind;
        logic       srcv;
        logic       dstv;
        logic       blk;
    } desc_attr_t;

    function automatic logic has_two_addr(desc_attr_t a);
        return (a.kind == 2'd1) || (a.srcv && a.dstv);
    endfunction

    function automatic logic [LEN_W-1:0] desc_words(desc_attr_t a);
        logic [LEN_W-1:0] n;
        case (a.kind)
            2'd1:    n = LEN_W'(12);
            2'd2:    n = has_two_addr(a) ? LEN_W'(8) : LEN_W'(7);
            default: n = has_two_addr(a) ? LEN_W'(4) : LEN_W'(3);
        endcase
        return n;
    endfunction
endpackage

// File: rtl/llw_fetch.sv
module llw_fetch #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] go_base,
    input  logic [LW-1:0] go_len,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          w_valid,
    output logic [LW-1:0] w_idx,
    output logic          w_last,
    output logic [DW-1:0] w_data
);
    typedef struct packed {
        logic          act;
        logic          wt;
        logic [LW-1:0] idx;
        logic [LW-1:0] len;
        logic [AW-1:0] base;
    } fst_t;

    fst_t q, d;

    assign rd_req  = q.act && !q.wt;
    assign rd_addr = q.base + (AW'(q.idx) << 2);
    assign w_valid = q.act && q.wt && rd_valid;
    assign w_idx   = q.idx;
    assign w_last  = q.idx == (q.len - 1'b1);
    assign w_data  = rd_data;

    always_comb begin
        d = q;
        if (go) begin
            d.act  = 1'b1;
            d.wt   = 1'b0;
            d.idx  = '0;
            d.len  = go_len;
            d.base = go_base;
        end else begin
            if (rd_req) d.wt = 1'b1;
            if (w_valid) begin
                d.wt  = 1'b0;
                d.idx = q.idx + 1'b1;
                if (w_last) d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/llw_xfer_hs.sv
module llw_xfer_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic xfer_start,
    input  logic xfer_done,
    output logic fin
);
    typedef struct packed {
        logic pend;
        logic busy;
    } hst_t;

    hst_t q, d;

    assign xfer_start = q.pend;
    assign fin        = q.busy && xfer_done;

    always_comb begin
        d      = q;
        d.pend = go;
        if (q.pend) d.busy = 1'b1;
        if (fin)    d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ll_desc_walker.sv
module ll_desc_walker
    import llw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              ptr_we,
    input  logic [ADDR_W-1:0] ptr_wdata,
    input  logic              chain_init,
    input  logic              start,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              xfer_start,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] p_src,
    output logic [ADDR_W-1:0] p_dst,
    output logic [FRM_W-1:0]  p_frames,
    output logic [ELM_W-1:0]  p_elems,
    output logic              blk_end,
    output logic [CNT_W-1:0]  done_cnt,
    output logic              paused,
    output logic [CTL_W-1:0]  ctl_word,
    output logic              finished
);
    typedef struct packed {
        walk_state_e       st;
        logic [CTL_W-1:0]  ctl;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] link;
        desc_attr_t        cur;
        desc_attr_t        pend;
        logic              from_desc;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [FRM_W-1:0]  frm;
        logic [ELM_W-1:0]  elm;
        logic [CNT_W-1:0]  cnt;
        logic              blk_pulse;
    } wst_t;

    wst_t q, d;

    logic              f_go, x_go, x_fin;
    logic [ADDR_W-1:0] f_base;
    logic [LEN_W-1:0]  f_len;
    logic              w_valid, w_last;
    logic [LEN_W-1:0]  w_idx, k;
    logic [WORD_W-1:0] w_data;
    desc_attr_t        head_attr;

    llw_fetch #(.AW(ADDR_W), .DW(WORD_W), .LW(LEN_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go(f_go), .go_base(f_base), .go_len(f_len),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .w_valid(w_valid), .w_idx(w_idx), .w_last(w_last), .w_data(w_data)
    );

    llw_xfer_hs u_hs (
        .clk(clk), .rst_n(rst_n), .go(x_go), .xfer_start(xfer_start),
        .xfer_done(xfer_done), .fin(x_fin)
    );

    assign head_attr.kind = q.ctl[CB_TLO+1:CB_TLO];
    assign head_attr.srcv = q.ctl[CB_SRCV];
    assign head_attr.dstv = q.ctl[CB_DSTV];
    assign head_attr.blk  = 1'b0;
    assign k              = w_idx - LEN_W'(2);

    always_comb begin
        d           = q;
        d.blk_pulse = 1'b0;
        f_go        = 1'b0;
        x_go        = 1'b0;
        f_base      = {q.link[ADDR_W-1:2], 2'b00};
        f_len       = desc_words(q.pend);
        if (ptr_we) d.ptr = ptr_wdata;
        if (ctl_we) d.ctl = ctl_wdata;
        case (q.st)
            S_IDLE, S_DONE: begin
                if (chain_init) begin
                    d.cnt = '0;
                    d.frm = '1;
                    d.elm = '1;
                end
                if (start) begin
                    d.link      = q.ptr;
                    d.pend      = head_attr;
                    d.from_desc = 1'b0;
                    if (q.ctl[CB_LL] && q.ctl[CB_FAST]) begin
                        d.st = S_LINK;
                    end else begin
                        d.st = S_EXEC;
                        x_go = 1'b1;
                    end
                end
            end
            S_LINK: begin
                if (!q.ctl[CB_LL] || q.link == END_PTR || q.pend.kind == 2'd0) begin
                    d.st = S_DONE;
                end else if (q.link[0]) begin
                    d.st           = S_PAUSE;
                    d.ctl[CB_PAUSE] = 1'b1;
                end else begin
                    d.st  = S_HDR;
                    d.cur = q.pend;
                    f_go  = 1'b1;
                end
            end
            S_PAUSE: begin
                if (start && !q.ctl[CB_PAUSE]) begin
                    d.st  = S_HDR;
                    d.cur = q.pend;
                    f_go  = 1'b1;
                end
            end
            S_HDR: begin
                if (w_valid) begin
                    if (w_idx == '0) begin
                        d.link = w_data;
                    end else begin
                        d.elm       = w_data[ELM_W-1:0];
                        d.pend.kind = w_data[HB_TLO+1:HB_TLO];
                        d.pend.srcv = w_data[HB_SRCV];
                        d.pend.dstv = w_data[HB_DSTV];
                        d.pend.blk  = w_data[HB_BLK];
                        d.st        = S_BODY;
                    end
                end
            end
            S_BODY: begin
                if (w_valid) begin
                    if (has_two_addr(q.cur)) begin
                        if (k == LEN_W'(0) && q.cur.srcv) d.src = w_data;
                        if (k == LEN_W'(1) && q.cur.dstv) d.dst = w_data;
                        if (k == LEN_W'(2) && q.cur.kind != 2'd3) d.frm = w_data[FRM_W-1:0];
                    end else begin
                        if (k == LEN_W'(0)) begin
                            if (q.cur.srcv)      d.src = w_data;
                            else if (q.cur.dstv) d.dst = w_data;
                        end
                        if (k == LEN_W'(1) && q.cur.kind == 2'd2) d.frm = w_data[FRM_W-1:0];
                    end
                    if (w_last) begin
                        d.st        = S_EXEC;
                        d.from_desc = 1'b1;
                        x_go        = 1'b1;
                    end
                end
            end
            S_EXEC: begin
                if (x_fin) begin
                    if (q.from_desc) begin
                        d.cnt       = q.cnt + 1'b1;
                        d.blk_pulse = q.cur.blk;
                    end
                    d.st = S_LINK;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= S_IDLE;
            q.frm <= '1;
            q.elm <= '1;
        end else begin
            q <= d;
        end
    end

    assign p_src    = q.src;
    assign p_dst    = q.dst;
    assign p_frames = q.frm;
    assign p_elems  = q.elm;
    assign blk_end  = q.blk_pulse;
    assign done_cnt = q.cnt;
    assign paused   = q.ctl[CB_PAUSE];
    assign ctl_word = q.ctl;
    assign finished = q.st == S_DONE;
endmodule

// File: rtl/llw_chk.sv
module llw_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_req,
    input logic [31:0] rd_addr,
    input logic        rd_valid,
    input logic        xfer_start,
    input logic        xfer_done,
    input logic [31:0] p_src,
    input logic [31:0] p_dst,
    input logic [15:0] p_frames,
    input logic [23:0] p_elems,
    input logic        paused,
    input logic [15:0] done_cnt,
    input logic        blk_end
);
    logic out_q;
    logic eng_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            eng_q <= 1'b0;
        end else begin
            if (rd_req)        out_q <= 1'b1;
            else if (rd_valid) out_q <= 1'b0;
            if (xfer_start)     eng_q <= 1'b1;
            else if (xfer_done) eng_q <= 1'b0;
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !out_q) else $error("outstanding read"); // R6
    AST_ALIGNED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ((rd_addr & 32'h3) == 32'h0)) else $error("unaligned read"); // R6
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start) else $error("start too long"); // R12
    AST_PARAMS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q |-> ($stable(p_src) && $stable(p_dst) && $stable(p_frames) && $stable(p_elems)))
        else $error("params moved"); // R12
    AST_NO_READ_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q |-> !rd_req) else $error("read during transfer"); // R7
    AST_NO_READ_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !rd_req) else $error("read while paused"); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_cnt != $past(done_cnt)) |-> ((done_cnt == $past(done_cnt) + 16'd1) || (done_cnt == 16'd0)))
        else $error("counter jump"); // R10
    AST_NOTIFY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |-> $past(xfer_done)) else $error("stray notify"); // R11
endmodule

bind ll_desc_walker llw_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .xfer_start(xfer_start), .xfer_done(xfer_done), .p_src(p_src), .p_dst(p_dst),
    .p_frames(p_frames), .p_elems(p_elems), .paused(paused), .done_cnt(done_cnt),
    .blk_end(blk_end)
);

// File: tb/sim_ll_desc_walker.sv
module sim_ll_desc_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0, ptr_we = 1'b0, chain_init = 1'b0, start = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [31:0] ptr_wdata = '0;
    logic        rd_req, rd_valid = 1'b0;
    logic [31:0] rd_addr, rd_data = '0;
    logic        xfer_start, xfer_done = 1'b0;
    logic [31:0] p_src, p_dst;
    logic [15:0] p_frames, done_cnt, ctl_word;
    logic [23:0] p_elems;
    logic        blk_end, paused, finished;

    always #4 clk = ~clk;

    ll_desc_walker u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .chain_init(chain_init), .start(start),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .xfer_start(xfer_start), .xfer_done(xfer_done), .p_src(p_src), .p_dst(p_dst),
        .p_frames(p_frames), .p_elems(p_elems), .blk_end(blk_end), .done_cnt(done_cnt),
        .paused(paused), .ctl_word(ctl_word), .finished(finished)
    );

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, blk_cnt = 0, eng_cnt = 0;
    logic [31:0] last_rd = '0;
    logic [31:0] mem [0:255];

    // memory: answers one cycle after each request
    always @(posedge clk) begin
        rd_valid <= rd_req;
        if (rd_req) begin
            rd_data <= mem[rd_addr[9:2]];
            rd_cnt  <= rd_cnt + 1;
            last_rd <= rd_addr;
        end
        if (blk_end) blk_cnt <= blk_cnt + 1;
    end

    // transfer engine: completes a few cycles after start
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt <= eng_cnt - 1;
            if (eng_cnt == 1) xfer_done <= 1'b1;
        end else if (xfer_start) begin
            eng_cnt <= 3;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [31:0] s;
        logic [31:0] d;
        logic [15:0] f;
        logic [23:0] e;
        int          rds;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    task automatic push(logic [31:0] s, logic [31:0] d, logic [15:0] f, logic [23:0] e,
                        int rds, string tag);
        exp_t it;
        it.s = s; it.d = d; it.f = f; it.e = e; it.rds = rds; it.tag = tag;
        sbq.push_back(it);
    endtask

    // monitor: compare each transfer against the scoreboard
    always @(negedge clk) begin
        if (rst_n && xfer_start) begin
            if (sbq.size() == 0) begin
                chk("R12 unexpected transfer", 1, 0);
            end else begin
                exp_t it;
                it = sbq.pop_front();
                chk({it.tag, " src"}, 64'(p_src), 64'(it.s));
                chk({it.tag, " dst"}, 64'(p_dst), 64'(it.d));
                chk({it.tag, " frames"}, 64'(p_frames), 64'(it.f));
                chk({it.tag, " elems"}, 64'(p_elems), 64'(it.e));
                chk({it.tag, " R7 reads before transfer"}, 64'(rd_cnt), 64'(it.rds));
            end
        end
    end

    task automatic wr_ctl(logic [15:0] v);
        ctl_wdata = v; ctl_we = 1'b1; @(negedge clk); ctl_we = 1'b0;
    endtask
    task automatic wr_ptr(logic [31:0] v);
        ptr_wdata = v; ptr_we = 1'b1; @(negedge clk); ptr_we = 1'b0;
    endtask
    task automatic pulse_init();
        chain_init = 1'b1; @(negedge clk); chain_init = 1'b0;
    endtask
    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask
    task automatic wait_stop();
        for (int i = 0; i < 3000 && !(finished || paused); i++) @(negedge clk);
    endtask

    function automatic logic [31:0] hdr1(int elems, bit sv, bit dv, bit blk, int typ);
        return 32'(elems) | (32'(sv) << 24) | (32'(dv) << 26) | (32'(blk) << 28) | (32'(typ) << 29);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA5A5_0000 + 32'(i);
        // chain A: fast mode, types 1, 2a, 2b, 3b
        mem[16] = 32'h80;  mem[17] = hdr1('h10, 1, 1, 1, 2);
        mem[18] = 32'h1000; mem[19] = 32'h2000; mem[20] = 32'h3;
        mem[32] = 32'hC0;  mem[33] = hdr1('h20, 1, 0, 0, 2);
        mem[34] = 32'h1100; mem[35] = 32'h2100; mem[36] = 32'h5;
        mem[48] = 32'h100; mem[49] = hdr1('h30, 0, 1, 0, 3);
        mem[50] = 32'h1200; mem[51] = 32'h7;
        mem[64] = 32'hFFFF_FFFC; mem[65] = hdr1('h40, 1, 1, 0, 3);
        mem[66] = 32'h2300;
        // chain B: normal mode, 3a with pause, then 3b without flags, zero type ends
        mem[128] = 32'h241; mem[129] = hdr1(5, 0, 0, 0, 3);
        mem[130] = 32'h3000; mem[131] = 32'h4000;
        mem[144] = 32'h280; mem[145] = hdr1(6, 0, 0, 0, 0);
        mem[146] = 32'h5555;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset count", 64'(done_cnt), 0);
        chk("R2 reset paused", 64'(paused), 0);
        chk("R2 reset frames", 64'(p_frames), 64'hFFFF);
        chk("R2 reset elems", 64'(p_elems), 64'hFF_FFFF);
        chk("R6 no read at reset", 64'(rd_req), 0);

        // scenario A
        push(32'h1000, 32'h2000, 16'd3, 24'h10, 12, "R1 R4 R5 type1");
        push(32'h1100, 32'h2100, 16'd5, 24'h20, 20, "R3 R4 long type2");
        push(32'h1200, 32'h2100, 16'd7, 24'h30, 27, "R5 short type2 src side");
        push(32'h1200, 32'h2300, 16'd7, 24'h40, 30, "R5 short type3 dst side");
        wr_ctl(16'h0515);
        wr_ptr(32'h40);
        pulse_init();
        pulse_start();
        wait_stop();
        repeat (4) @(negedge clk);
        chk("R7 scoreboard drained A", 64'(sbq.size()), 0);
        chk("R9 finished A", 64'(finished), 1);
        chk("R9 no read past end", 64'(rd_cnt), 30);
        chk("R6 last read address", 64'(last_rd), 64'h108);
        chk("R10 count A", 64'(done_cnt), 4);
        chk("R11 one notification", 64'(blk_cnt), 1);

        // scenario B
        pulse_init();
        chk("R2 init count", 64'(done_cnt), 0);
        chk("R2 init frames", 64'(p_frames), 64'hFFFF);
        chk("R2 init elems", 64'(p_elems), 64'hFF_FFFF);
        chk("R2 init keeps src", 64'(p_src), 64'h1200);
        push(32'h1200, 32'h2300, 16'hFFFF, 24'hFF_FFFF, 30, "R7 preloaded transfer");
        push(32'h3000, 32'h4000, 16'hFFFF, 24'd5, 34, "R4 long type3");
        wr_ctl(16'h0135);
        wr_ptr(32'h200);
        pulse_start();
        wait_stop();
        repeat (3) @(negedge clk);
        chk("R8 paused", 64'(paused), 1);
        chk("R8 ctl word bit7", 64'(ctl_word), 64'h01B5);
        chk("R10 preloaded not counted", 64'(done_cnt), 1);
        repeat (20) @(negedge clk);
        chk("R8 no read while paused", 64'(rd_cnt), 34);
        pulse_start();
        repeat (10) @(negedge clk);
        chk("R8 start ignored while flag set", 64'(rd_cnt), 34);
        chk("R8 still paused", 64'(paused), 1);
        push(32'h3000, 32'h4000, 16'hFFFF, 24'd6, 37, "R5 no-flag address ignored");
        wr_ctl(16'h0135);
        pulse_start();
        wait_stop();
        repeat (3) @(negedge clk);
        chk("R9 zero type ends", 64'(finished), 1);
        chk("R8 resume address", 64'(last_rd), 64'h248);
        chk("R9 no read after zero type", 64'(rd_cnt), 37);
        chk("R10 count B", 64'(done_cnt), 2);

        // scenario C: list walking disabled
        push(32'h3000, 32'h4000, 16'hFFFF, 24'd6, 37, "R13 single transfer");
        wr_ctl(16'h0000);
        pulse_start();
        wait_stop();
        repeat (3) @(negedge clk);
        chk("R13 finished", 64'(finished), 1);
        chk("R13 no reads", 64'(rd_cnt), 37);
        chk("R13 count unchanged", 64'(done_cnt), 2);
        chk("R12 scoreboard drained", 64'(sbq.size()), 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule